// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A memory-mapped watchdog with a plain 32-bit register port: a byte address, write data, a write strobe and registered read data. The host loads a down-counter with a timeout measured in ticks, where a tick is a one-cycle pulse from an external prescaler. While the watchdog is enabled, every tick takes one off the counter. The host keeps the system alive by writing a fresh count before the counter runs out.

Two sticky interrupt flags report what happened. An early-warning flag is set when the count steps down onto a programmed threshold. An expiry flag is set when the count reaches zero. Each flag drives its own level interrupt output, and the host clears the flags through a write-1-to-clear status register.

Stray writes are guarded against. Before each register write, the host must write a fixed 32-bit key to the unlock register. One key enables exactly one following write. A write made without a pending key changes nothing.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the count, threshold, enable, both flags and the read data are all zero, and both interrupt outputs are low.
- R2: Writing the key 0xF1D0DEAD to the unlock register (byte offset 0x0C) arms the block, and the next write to another register then takes effect.
- R3: A write to the count (0x00), threshold (0x04), enable (0x08) or status (0x10) register made while the block is not armed leaves every register and flag unchanged.
- R4: An unlock is used up by the very next write to any address. A second write needs a new key, and a write of any other value to the unlock register disarms the block.
- R5: Bit 0 of the enable register (0x08) gates counting. While it is 1, each tick pulse lowers the count by one. While it is 0, the count does not move. The enable register reads back only bit 0.
- R6: An accepted write to the count register loads the written value, and this refreshes the watchdog. Reading offset 0x00 returns the ticks remaining.
- R7: With a nonzero threshold, the early-warning flag (status bit 8, output irq_warn) is set when a tick steps the count down to the threshold value. A threshold of 0 never sets this flag.
- R8: The expiry flag (status bit 9, output irq_expire) is set when a tick steps the count from 1 to 0. After that the count stays at 0, with no wrap, until it is reloaded.
- R9: An accepted write to the status register (0x10) clears flag bit 8 and/or bit 9 wherever the written data has a 1. Reading 0x10 returns the flags in bits 9:8. The interrupt outputs follow the flags.
- R10: Read data is registered. The value for an address appears one clock after that address is presented. Unlock and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse that decrements the enabled counter |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_warn | output | 1 | Early-warning interrupt level |
| irq_expire | output | 1 | Expiry interrupt level |

## Verification
A write, or a tick, is presented before a clock edge. Its effect on the count, the threshold, the enable bit and the flags is in place right after that edge, so the interrupt outputs are sampled one time unit after it. Read data takes one more edge: the bench sets the address, waits one edge and then samples, and it does this only in cycles with no write and no tick, so the value read is the settled state. Tick bursts are counted exactly, which lets the early-warning and expiry checks land on the first cycle each flag can rise, and also on the cycle just before it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'hF1D0_DEAD;
  localparam logic [7:0]  OFF_COUNT  = 8'h00;
  localparam logic [7:0]  OFF_THRESH = 8'h04;
  localparam logic [7:0]  OFF_ENABLE = 8'h08;
  localparam logic [7:0]  OFF_UNLOCK = 8'h0C;
  localparam logic [7:0]  OFF_STATUS = 8'h10;
  localparam int          WARN_BIT   = 8;
  localparam int          EXPIRE_BIT = 9;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              hit_unlock,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed
);
  import wdog_pkg::*;

  logic key_ok;
  assign key_ok = hit_unlock && (wdata == DATA_W'(UNLOCK_KEY));

  always_ff @(posedge clk) begin
    if (rst)     armed <= 1'b0;
    else if (we) armed <= key_ok;
  end

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !hit_unlock) |=> !armed);

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    (we && hit_unlock && wdata == DATA_W'(UNLOCK_KEY)) |=> armed);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             thr_we,
  input  logic [CNT_W-1:0] thr_val,
  input  logic             en_we,
  input  logic             en_val,
  input  logic             clr_we,
  input  logic [1:0]       clr_mask,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] thr,
  output logic             en,
  output logic             warn,
  output logic             expire
);
  logic             step;
  logic [CNT_W-1:0] cnt_next;
  logic             warn_set, exp_set;

  assign step     = en && tick && !load && (cnt != '0);
  assign cnt_next = cnt - 1'b1;
  assign warn_set = step && (thr != '0) && (cnt_next == thr);
  assign exp_set  = step && (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      thr    <= '0;
      en     <= 1'b0;
      warn   <= 1'b0;
      expire <= 1'b0;
    end else begin
      if (load)        cnt <= load_val;
      else if (step)   cnt <= cnt_next;
      if (thr_we)      thr <= thr_val;
      if (en_we)       en  <= en_val;
      warn   <= warn_set | (warn   & ~(clr_we & clr_mask[0]));
      expire <= exp_set  | (expire & ~(clr_we & clr_mask[1]));
    end
  end

  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5
  stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (cnt == '0));

  // R8
  expire_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !load && cnt == CNT_W'(1)) |=> expire);

  // R7
  warn_off_chk: assert property (@(posedge clk) disable iff (rst)
    (thr == '0 && !warn) |=> !warn);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_mask[1] && !(en && tick && !load && cnt == CNT_W'(1))) |=> !expire);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_warn,
  output logic              irq_expire
);
  import wdog_pkg::*;

  localparam int CNT_W = DATA_W;

  logic hit_cnt, hit_thr, hit_en, hit_unl, hit_stat;
  logic armed, wr_ok;
  logic [CNT_W-1:0] cnt, thr;
  logic en, warn, expire;

  assign hit_cnt  = bus_addr == OFF_COUNT[ADDR_W-1:0];
  assign hit_thr  = bus_addr == OFF_THRESH[ADDR_W-1:0];
  assign hit_en   = bus_addr == OFF_ENABLE[ADDR_W-1:0];
  assign hit_unl  = bus_addr == OFF_UNLOCK[ADDR_W-1:0];
  assign hit_stat = bus_addr == OFF_STATUS[ADDR_W-1:0];
  assign wr_ok    = bus_we && armed && !hit_unl;

  wdog_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk(clk), .rst(rst), .we(bus_we), .hit_unlock(hit_unl),
    .wdata(bus_wdata), .armed(armed)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .tick(tick),
    .load(wr_ok && hit_cnt), .load_val(bus_wdata),
    .thr_we(wr_ok && hit_thr), .thr_val(bus_wdata),
    .en_we(wr_ok && hit_en), .en_val(bus_wdata[0]),
    .clr_we(wr_ok && hit_stat),
    .clr_mask({bus_wdata[EXPIRE_BIT], bus_wdata[WARN_BIT]}),
    .cnt(cnt), .thr(thr), .en(en), .warn(warn), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (hit_cnt) bus_rdata <= cnt;
      if (hit_thr) bus_rdata <= thr;
      if (hit_en)  bus_rdata <= DATA_W'(en);
      if (hit_stat) begin
        bus_rdata[WARN_BIT]   <= warn;
        bus_rdata[EXPIRE_BIT] <= expire;
      end
    end
  end

  assign irq_warn   = warn;
  assign irq_expire = expire;

  // R3
  no_key_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !armed && !hit_unl) |=> ($stable(thr) && $stable(en)));

  // R10
  unlock_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hit_unl |=> (bus_rdata == '0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !armed) |=> ($stable(irq_warn) || $rose(irq_warn)));
endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [31:0] KEY = 32'hF1D0_DEAD;

  // entry: {req[3:0], op[1:0], addr[4:0], data[31:0], expected[31:0]}
  // op 0 = keyed write, 1 = write without key, 2 = read and compare
  localparam int NV = 11;
  localparam logic [74:0] VEC [NV] = '{
    {4'd2,  2'd0, 5'h04, 32'h0000_0011, 32'h0},
    {4'd2,  2'd2, 5'h04, 32'h0,         32'h0000_0011},
    {4'd6,  2'd0, 5'h00, 32'h1234_5678, 32'h0},
    {4'd6,  2'd2, 5'h00, 32'h0,         32'h1234_5678},
    {4'd3,  2'd1, 5'h04, 32'h0000_0099, 32'h0},
    {4'd3,  2'd2, 5'h04, 32'h0,         32'h0000_0011},
    {4'd10, 2'd2, 5'h0C, 32'h0,         32'h0},
    {4'd5,  2'd0, 5'h08, 32'h0000_0003, 32'h0},
    {4'd5,  2'd2, 5'h08, 32'h0,         32'h0000_0001},
    {4'd5,  2'd0, 5'h08, 32'h0,         32'h0},
    {4'd9,  2'd2, 5'h10, 32'h0,         32'h0}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_warn, irq_expire;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_warn(irq_warn), .irq_expire(irq_expire)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic kwr(input logic [4:0] a, input logic [31:0] d);
    wr(5'h0C, KEY);
    wr(a, d);
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1", {30'b0, irq_expire, irq_warn}, 32'h0);
    rd("R1", 5'h00, 32'h0);
    rd("R1", 5'h08, 32'h0);
    rd("R1", 5'h04, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][70:69])
        2'd0: kwr(VEC[i][68:64], VEC[i][63:32]);
        2'd1: wr(VEC[i][68:64], VEC[i][63:32]);
        default: rd($sformatf("R%0d", VEC[i][74:71]), VEC[i][68:64], VEC[i][31:0]);
      endcase
    end

    // R4 one key, one write
    kwr(5'h04, 32'h22);
    wr(5'h04, 32'h33);
    rd("R4", 5'h04, 32'h22);
    wr(5'h0C, KEY);
    wr(5'h0C, 32'h1);
    wr(5'h04, 32'h44);
    rd("R4", 5'h04, 32'h22);

    // R5 disabled: ticks do not move the count
    kwr(5'h00, 32'd5);
    ticks(3);
    rd("R5", 5'h00, 32'd5);

    // R7 warning at threshold 2, R8 expiry at zero
    kwr(5'h04, 32'd2);
    kwr(5'h08, 32'd1);
    ticks(2);
    check("R7", {31'b0, irq_warn}, 32'd0);
    ticks(1);
    check("R7", {31'b0, irq_warn}, 32'd1);
    rd("R5", 5'h00, 32'd2);
    ticks(1);
    check("R8", {31'b0, irq_expire}, 32'd0);
    ticks(1);
    check("R8", {31'b0, irq_expire}, 32'd1);
    ticks(4);
    rd("R8", 5'h00, 32'd0);
    rd("R9", 5'h10, 32'h300);

    // R3 status clear without key ignored
    wr(5'h10, 32'h300);
    check("R3", {30'b0, irq_expire, irq_warn}, 32'h3);
    // R9 per-bit clear
    kwr(5'h10, 32'h100);
    check("R9", {30'b0, irq_expire, irq_warn}, 32'h2);
    rd("R9", 5'h10, 32'h200);
    kwr(5'h10, 32'h200);
    check("R9", {30'b0, irq_expire, irq_warn}, 32'h0);

    // R6 refresh while counting
    kwr(5'h00, 32'd10);
    ticks(3);
    rd("R6", 5'h00, 32'd7);
    kwr(5'h00, 32'd10);
    rd("R6", 5'h00, 32'd10);

    // R7 threshold zero never warns
    kwr(5'h04, 32'd0);
    kwr(5'h00, 32'd2);
    ticks(3);
    check("R7", {31'b0, irq_warn}, 32'd0);
    check("R8", {31'b0, irq_expire}, 32'd1);

    // R1 reset clears flags
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check("R1", {30'b0, irq_expire, irq_warn}, 32'h0);
    rd("R1", 5'h08, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule